// File: doc/BRIEF.md
# Indexed Triangle Assembler with Post-Transform Vertex Cache

This block turns a stream of vertex indices into triangles. Every three accepted indices form one triangle. Each index is first looked up in a small cache of vertices that have already been transformed. A hit reuses the stored result. A miss sends one transform request to an external shading unit. The request names the index and carries a tag that identifies the cache slot. Results come back tagged, in any order, and are written into their slots.

Completed triangles wait in a four-entry pending buffer. They are sent downstream in arrival order, once all three corners hold transformed data. New indices keep flowing while earlier triangles wait for results or for the downstream side.

The cache has sixteen entries and replaces the oldest entry first. An entry that a waiting or half-built triangle still refers to is skipped by the replacement pointer. It is never overwritten.

Top module: `tri_vtx_assembler`

## Requirements
- R1: Three consecutively accepted indices form one triangle. `tri_v0`, `tri_v1` and `tri_v2` carry the vertices of the first, second and third index respectively.
- R2: An index that misses the cache produces exactly one request. `xf_req_index` carries the index and `xf_req_tag` carries the cache slot. Both stay stable until `xf_req_ready` is seen.
- R3: An index that is already resident, or whose transform is already requested, produces no further request. This holds within one triangle and across pending triangles.
- R4: A triangle is presented only after the results for all three of its corners have arrived. Each corner carries the data returned for its index.
- R5: Triangles leave in the order their indices arrived, even when results return out of order. A result is matched to its request only by tag.
- R6: While `tri_valid` is high and `tri_ready` is low, `tri_valid` and all three vertex outputs hold their values.
- R7: `idx_ready` is low while four completed triangles wait in the pending buffer.
- R8: An index that was transformed earlier and is still cached is a hit and issues no request. The cache holds 16 entries with oldest-first replacement.
- R9: Replacement never takes an entry that a pending or partly gathered triangle refers to. The pointer steps past such an entry.
- R10: After reset, `tri_valid` and `xf_req_valid` are low and `idx_ready` is high.
- R11: A result is taken on every cycle that `xf_rsp_valid` is high; there is no ready signal. Its tag is always the tag of an outstanding request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_valid | input | 1 | Index stream valid |
| idx_ready | output | 1 | Index stream ready |
| idx_data | input | IDX_W | Vertex index |
| xf_req_valid | output | 1 | Transform request valid |
| xf_req_ready | input | 1 | Transform request accepted |
| xf_req_index | output | IDX_W | Index to transform |
| xf_req_tag | output | SLOT_W | Cache slot tag of the request |
| xf_rsp_valid | input | 1 | Transform result valid |
| xf_rsp_tag | input | SLOT_W | Tag of the returned result |
| xf_rsp_vertex | input | VTX_W | Transformed vertex data |
| tri_valid | output | 1 | Triangle output valid |
| tri_ready | input | 1 | Downstream ready |
| tri_v0 | output | VTX_W | First corner vertex |
| tri_v1 | output | VTX_W | Second corner vertex |
| tri_v2 | output | VTX_W | Third corner vertex |

## Verification
The assertions watch the handshake rules on every cycle:
- the triangle output and the request channel hold while stalled;
- `idx_ready` never rises while the pending buffer is full;
- no tag is requested a second time while it is outstanding;
- every result tag matches an outstanding request.

Only the bench scenarios can show that the right vertex lands in the right corner and that the order holds when results return in reverse. They also show how many requests sharing and duplicates cause, and that the replacement pointer skips an entry a half-built triangle still uses.

// File: rtl/pa_pkg.sv
package pa_pkg;
  // Position of the next accepted index within the triangle being gathered
  typedef enum logic [1:0] {
    CORNER_A = 2'd0,
    CORNER_B = 2'd1,
    CORNER_C = 2'd2
  } corner_e;
endpackage

// File: rtl/pa_vcache.sv
module pa_vcache #(
  parameter int IDX_W  = 16,
  parameter int VTX_W  = 32,
  parameter int SLOTS  = 16,
  parameter int REF_W  = 4,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [IDX_W-1:0]            lk_idx,
  output logic                        lk_hit,
  output logic [SLOT_W-1:0]           lk_slot,
  output logic [SLOT_W-1:0]           vic_slot,
  output logic                        vic_free,
  input  logic                        alloc_en,
  input  logic                        skip_en,
  input  logic                        ref_en,
  input  logic [SLOT_W-1:0]           ref_slot,
  input  logic                        rel_en,
  input  logic [2:0][SLOT_W-1:0]      rel_slot,
  input  logic                        fill_en,
  input  logic [SLOT_W-1:0]           fill_slot,
  input  logic [VTX_W-1:0]            fill_data,
  input  logic [2:0][SLOT_W-1:0]      rd_slot,
  output logic [2:0][VTX_W-1:0]       rd_data,
  output logic [2:0]                  rd_rdy
);
  logic [IDX_W-1:0] tag_q [SLOTS];
  logic [REF_W-1:0] rc_q  [SLOTS];
  logic [REF_W-1:0] inc_v [SLOTS];
  logic [REF_W-1:0] dec_v [SLOTS];
  logic [VTX_W-1:0] mem   [SLOTS];
  logic [SLOTS-1:0] val_q, rdy_q;
  logic [SLOT_W-1:0] ptr_q;

  // Tag compare across all entries; dedup keeps at most one match
  always_comb begin
    lk_hit  = 1'b0;
    lk_slot = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (val_q[s] && tag_q[s] == lk_idx) begin
        lk_hit  = 1'b1;
        lk_slot = SLOT_W'(s);
      end
    end
  end

  assign vic_slot = ptr_q;
  assign vic_free = (rc_q[ptr_q] == '0);

  // Reference counts: one per corner that names the slot
  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      inc_v[s] = REF_W'(ref_en && ref_slot == SLOT_W'(s));
      dec_v[s] = '0;
      for (int k = 0; k < 3; k++)
        dec_v[s] = dec_v[s] + REF_W'(rel_en && rel_slot[k] == SLOT_W'(s));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      val_q <= '0;
      rdy_q <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        rc_q[s]  <= '0;
        tag_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        rc_q[s] <= rc_q[s] + inc_v[s] - dec_v[s];
        if (alloc_en && ptr_q == SLOT_W'(s)) begin
          val_q[s] <= 1'b1;
          rdy_q[s] <= 1'b0;
          tag_q[s] <= lk_idx;
        end else if (fill_en && fill_slot == SLOT_W'(s)) begin
          rdy_q[s] <= 1'b1;
        end
      end
      if (alloc_en || skip_en)
        ptr_q <= (ptr_q == SLOT_W'(SLOTS-1)) ? '0 : ptr_q + 1'b1;
    end
  end

  // Vertex storage: single write port, no reset
  always_ff @(posedge clk) begin
    if (fill_en) mem[fill_slot] <= fill_data;
  end

  generate
    for (genvar k = 0; k < 3; k++) begin : g_rd
      assign rd_data[k] = mem[rd_slot[k]];
      assign rd_rdy[k]  = rdy_q[rd_slot[k]];
    end
  endgenerate
endmodule

// File: rtl/pa_pend_fifo.sv
module pa_pend_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head_data,
  output logic             not_empty,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  assign head_data = mem[rd_q];
  assign not_empty = (count != '0);
endmodule

// File: rtl/tri_vtx_assembler.sv
module tri_vtx_assembler #(
  parameter int IDX_W = 16,
  parameter int VTX_W = 32,
  parameter int SLOTS = 16,
  parameter int PEND  = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int REF_W  = $clog2(3*PEND + 4),
  localparam int CNT_W  = $clog2(PEND + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_valid,
  output logic              idx_ready,
  input  logic [IDX_W-1:0]  idx_data,
  output logic              xf_req_valid,
  input  logic              xf_req_ready,
  output logic [IDX_W-1:0]  xf_req_index,
  output logic [SLOT_W-1:0] xf_req_tag,
  input  logic              xf_rsp_valid,
  input  logic [SLOT_W-1:0] xf_rsp_tag,
  input  logic [VTX_W-1:0]  xf_rsp_vertex,
  output logic              tri_valid,
  input  logic              tri_ready,
  output logic [VTX_W-1:0]  tri_v0,
  output logic [VTX_W-1:0]  tri_v1,
  output logic [VTX_W-1:0]  tri_v2
);
  import pa_pkg::*;

  logic                   lk_hit, vic_free;
  logic [SLOT_W-1:0]      lk_slot, vic_slot, cur_slot;
  logic [2:0][SLOT_W-1:0] head_slots;
  logic [2:0][VTX_W-1:0]  rd_data;
  logic [2:0]             rd_rdy;
  logic                   head_nz, head_ok, load_out;
  logic [CNT_W-1:0]       pend_cnt;
  logic                   space, req_free, accept, take_miss, skip_en, push;

  corner_e           corner_q;
  logic [SLOT_W-1:0] c0_q, c1_q;

  assign space     = (pend_cnt != CNT_W'(PEND));
  assign req_free  = !xf_req_valid || xf_req_ready;
  assign idx_ready = space && (lk_hit || (vic_free && req_free));
  assign accept    = idx_valid && idx_ready;
  assign take_miss = accept && !lk_hit;
  assign skip_en   = idx_valid && space && !lk_hit && !vic_free;
  assign cur_slot  = lk_hit ? lk_slot : vic_slot;
  assign push      = accept && (corner_q == CORNER_C);

  assign head_ok  = head_nz && (&rd_rdy);
  assign load_out = head_ok && (!tri_valid || tri_ready);

  pa_vcache #(
    .IDX_W(IDX_W), .VTX_W(VTX_W), .SLOTS(SLOTS), .REF_W(REF_W)
  ) u_cache (
    .clk(clk), .rst(rst),
    .lk_idx(idx_data), .lk_hit(lk_hit), .lk_slot(lk_slot),
    .vic_slot(vic_slot), .vic_free(vic_free),
    .alloc_en(take_miss), .skip_en(skip_en),
    .ref_en(accept), .ref_slot(cur_slot),
    .rel_en(load_out), .rel_slot(head_slots),
    .fill_en(xf_rsp_valid), .fill_slot(xf_rsp_tag), .fill_data(xf_rsp_vertex),
    .rd_slot(head_slots), .rd_data(rd_data), .rd_rdy(rd_rdy)
  );

  pa_pend_fifo #(
    .W(3*SLOT_W), .DEPTH(PEND)
  ) u_pend (
    .clk(clk), .rst(rst),
    .push(push), .push_data({c0_q, c1_q, cur_slot}),
    .pop(load_out), .head_data(head_slots),
    .not_empty(head_nz), .count(pend_cnt)
  );

  // Corner gathering
  always_ff @(posedge clk) begin
    if (rst) begin
      corner_q <= CORNER_A;
      c0_q     <= '0;
      c1_q     <= '0;
    end else if (accept) begin
      unique case (corner_q)
        CORNER_A: begin c0_q <= cur_slot; corner_q <= CORNER_B; end
        CORNER_B: begin c1_q <= cur_slot; corner_q <= CORNER_C; end
        default:  corner_q <= CORNER_A;
      endcase
    end
  end

  // Single outstanding-issue request register
  always_ff @(posedge clk) begin
    if (rst) begin
      xf_req_valid <= 1'b0;
      xf_req_index <= '0;
      xf_req_tag   <= '0;
    end else if (take_miss) begin
      xf_req_valid <= 1'b1;
      xf_req_index <= idx_data;
      xf_req_tag   <= vic_slot;
    end else if (xf_req_ready) begin
      xf_req_valid <= 1'b0;
    end
  end

  // Registered triangle output; data captured before slot release
  always_ff @(posedge clk) begin
    if (rst) begin
      tri_valid <= 1'b0;
      tri_v0    <= '0;
      tri_v1    <= '0;
      tri_v2    <= '0;
    end else if (load_out) begin
      tri_valid <= 1'b1;
      tri_v0    <= rd_data[2];
      tri_v1    <= rd_data[1];
      tri_v2    <= rd_data[0];
    end else if (tri_ready) begin
      tri_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pa_assembler_chk.sv
module pa_assembler_chk #(
  parameter int IDX_W = 16,
  parameter int VTX_W = 32,
  parameter int SLOTS = 16,
  parameter int PEND  = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(PEND + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              idx_ready,
  input logic [CNT_W-1:0]  pend_cnt,
  input logic              xf_req_valid,
  input logic              xf_req_ready,
  input logic [IDX_W-1:0]  xf_req_index,
  input logic [SLOT_W-1:0] xf_req_tag,
  input logic              xf_rsp_valid,
  input logic [SLOT_W-1:0] xf_rsp_tag,
  input logic              tri_valid,
  input logic              tri_ready,
  input logic [VTX_W-1:0]  tri_v0,
  input logic [VTX_W-1:0]  tri_v1,
  input logic [VTX_W-1:0]  tri_v2
);
  logic [SLOTS-1:0] inflight_q;

  always_ff @(posedge clk) begin
    if (rst) inflight_q <= '0;
    else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (xf_req_valid && xf_req_ready && xf_req_tag == SLOT_W'(s))
          inflight_q[s] <= 1'b1;
        else if (xf_rsp_valid && xf_rsp_tag == SLOT_W'(s))
          inflight_q[s] <= 1'b0;
      end
    end
  end

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tri_valid && !tri_ready |=> tri_valid && $stable(tri_v0) && $stable(tri_v1) && $stable(tri_v2));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    xf_req_valid && !xf_req_ready |=> xf_req_valid && $stable(xf_req_index) && $stable(xf_req_tag));

  // R7
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    idx_ready |-> pend_cnt < CNT_W'(PEND));

  // R3
  no_dup_req_chk: assert property (@(posedge clk) disable iff (rst)
    xf_req_valid && xf_req_ready |-> !inflight_q[xf_req_tag]);

  // R11
  rsp_known_tag_chk: assert property (@(posedge clk) disable iff (rst)
    xf_rsp_valid |-> inflight_q[xf_rsp_tag]);
endmodule

bind tri_vtx_assembler pa_assembler_chk #(
  .IDX_W(IDX_W), .VTX_W(VTX_W), .SLOTS(SLOTS), .PEND(PEND)
) u_chk (
  .clk(clk), .rst(rst), .idx_ready(idx_ready), .pend_cnt(pend_cnt),
  .xf_req_valid(xf_req_valid), .xf_req_ready(xf_req_ready),
  .xf_req_index(xf_req_index), .xf_req_tag(xf_req_tag),
  .xf_rsp_valid(xf_rsp_valid), .xf_rsp_tag(xf_rsp_tag),
  .tri_valid(tri_valid), .tri_ready(tri_ready),
  .tri_v0(tri_v0), .tri_v1(tri_v1), .tri_v2(tri_v2)
);

// File: tb/tri_vtx_assembler_test.sv
`timescale 1ns/1ps
module tri_vtx_assembler_test;
  logic        clk = 1'b0, rst = 1'b1;
  logic        idx_valid = 1'b0, xf_req_ready = 1'b1, tri_ready = 1'b1;
  logic [15:0] idx_data = '0;
  logic        idx_ready, xf_req_valid, tri_valid;
  logic [15:0] xf_req_index;
  logic [3:0]  xf_req_tag;
  logic        xf_rsp_valid;
  logic [3:0]  xf_rsp_tag;
  logic [31:0] xf_rsp_vertex, tri_v0, tri_v1, tri_v2;

  always #2 clk = ~clk;

  tri_vtx_assembler uut (.*);

  int checks = 0, fails = 0, req_total = 0, gn = 0, ot_n = 0;
  int reqcnt [256];
  logic [15:0] ot_idx [32];
  logic [3:0]  ot_tag [32];
  logic [95:0] got [64];
  logic rsp_hold = 1'b0, rsp_lifo = 1'b1;

  function automatic logic [31:0] vf(input logic [15:0] i);
    return {i ^ 16'h5A3C, i};
  endfunction
  function automatic logic [95:0] tf(input logic [15:0] a, b, c);
    return {vf(a), vf(b), vf(c)};
  endfunction

  // Transform model: records requests, returns tagged results (FIFO or LIFO)
  always @(posedge clk) begin
    if (rst) begin
      ot_n = 0;
      xf_rsp_valid <= 1'b0;
      for (int i = 0; i < 256; i++) reqcnt[i] = 0;
    end else begin
      if (xf_req_valid && xf_req_ready) begin
        ot_idx[ot_n] = xf_req_index;
        ot_tag[ot_n] = xf_req_tag;
        ot_n++;
        req_total++;
        reqcnt[xf_req_index[7:0]]++;
      end
      xf_rsp_valid <= 1'b0;
      if (!rsp_hold && ot_n > 0) begin
        automatic int k = rsp_lifo ? ot_n - 1 : 0;
        xf_rsp_valid  <= 1'b1;
        xf_rsp_tag    <= ot_tag[k];
        xf_rsp_vertex <= vf(ot_idx[k]);
        for (int j = k; j < ot_n - 1; j++) begin
          ot_idx[j] = ot_idx[j+1];
          ot_tag[j] = ot_tag[j+1];
        end
        ot_n--;
      end
    end
  end

  always @(posedge clk) begin
    if (!rst && tri_valid && tri_ready && gn < 64) begin
      got[gn] = {tri_v0, tri_v1, tri_v2};
      gn++;
    end
  end

  task automatic chk(input string req, input logic [95:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] v);
    @(negedge clk);
    idx_valid = 1'b1;
    idx_data  = v;
    #1;
    while (!idx_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    idx_valid = 1'b0;
  endtask

  task automatic wait_tris(input int n);
    int t = 0;
    while (gn < n && t < 400) begin @(negedge clk); t++; end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Row: three indices, then the number of new requests the row must cause
  localparam logic [55:0] TBL [8] = '{
    {16'd1,   16'd2,  16'd3,  8'd3},   // cold misses
    {16'd3,   16'd2,  16'd4,  8'd1},   // reuse of shared corners
    {16'd5,   16'd5,  16'd6,  8'd2},   // duplicate inside a triangle
    {16'd7,   16'd8,  16'd1,  8'd2},
    {16'd9,   16'd9,  16'd9,  8'd1},   // degenerate triangle
    {16'd10,  16'd11, 16'd12, 8'd3},
    {16'd12,  16'd11, 16'd13, 8'd1},
    {16'd255, 16'd0,  16'd10, 8'd2}
  };

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int exp_req = 0, base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R10: quiet outputs, ready to accept
    chk("R10", {93'd0, tri_valid, xf_req_valid, idx_ready}, 96'd1);

    // Table walk: R1, R3, R4, R8
    for (int r = 0; r < 8; r++) begin
      send(TBL[r][55:40]);
      send(TBL[r][39:24]);
      send(TBL[r][23:8]);
      repeat (4) @(negedge clk);
      exp_req += int'(TBL[r][7:0]);
      chk("R3/R8 request count", 96'(req_total), 96'(exp_req));
    end
    wait_tris(8);
    for (int r = 0; r < 8; r++)
      chk("R1/R4 triangle", got[r], tf(TBL[r][55:40], TBL[r][39:24], TBL[r][23:8]));
    chk("R3 single request for repeated index", 96'(reqcnt[5] + reqcnt[9]), 96'd2);

    // Out-of-order results: R2, R4, R5
    rsp_hold = 1'b1;
    base = req_total;
    for (int i = 20; i < 26; i++) send(16'(i));
    repeat (4) @(negedge clk);
    chk("R2 one request per miss", 96'(req_total - base), 96'd6);
    chk("R4 no triangle before results", {95'd0, tri_valid}, 96'd0);
    rsp_hold = 1'b0;
    wait_tris(10);
    chk("R5 first triangle in order", got[8], tf(16'd20, 16'd21, 16'd22));
    chk("R5 second triangle in order", got[9], tf(16'd23, 16'd24, 16'd25));

    // Backpressure: R6, R7
    rsp_lifo = 1'b0;
    tri_ready = 1'b0;
    for (int t = 0; t < 5; t++) begin send(16'd40); send(16'd41); send(16'd42); end
    repeat (6) @(negedge clk);
    chk("R7 input blocked when buffer full", {95'd0, idx_ready}, 96'd0);
    chk("R6 output presented", {tri_v0, tri_v1, tri_v2}, tf(16'd40, 16'd41, 16'd42));
    repeat (3) @(negedge clk);
    chk("R6 held under stall", {95'd0, tri_valid}, 96'd1);
    tri_ready = 1'b1;
    wait_tris(15);
    chk("R6 all held triangles drained", 96'(gn), 96'd15);
    chk("R6 last drained triangle", got[14], tf(16'd40, 16'd41, 16'd42));

    // R9: index 9 sits in the oldest slot; a later miss must skip it
    send(16'd9);
    send(16'd60);
    send(16'd61);
    wait_tris(16);
    chk("R9 referenced entry kept", got[15], tf(16'd9, 16'd60, 16'd61));
    chk("R9 no refetch of kept index", 96'(reqcnt[9]), 96'd1);
    chk("R11 all results consumed", 96'(ot_n), 96'd0);

    finish_run();
  end
endmodule